// File: doc/BRIEF.md
# Ring Interrupt Status Register Bank

This block holds the interrupt state of one DMA ring in a host controller. Seven hardware event pulses enter it: ring operation done, transfer completion, transfer error, transfer abort, in-band interrupt ready, in-band interrupt ring full, and a warning that a stop was inserted on a mode change. Each pulse can latch into a sticky status bit. A single level interrupt output is raised from the latched bits that software has chosen to signal.

Software reaches the block through a plain 32-bit register port. The port has a byte address, a write strobe, write data and combinational read data. Behind it sit four registers at fixed offsets from the ring's register base.

- Offset 0x10 is status, cleared by writing ones.
- Offset 0x14 is the latch gate, called status enable.
- Offset 0x18 is the interrupt gate, called signal enable.
- Offset 0x1C is a force register that injects events.

Because latching and signalling are gated separately, software can record every event while only a chosen subset drives the line. Software clears status by writing back the value it read.

Top module: `ring_irq_bank`

## Requirements
- R1: After reset, status, status enable and signal enable read zero, force reads zero, and `irq_o` is low.
- R2: Event input `ev_i[k]` maps to register bit 5+k for k in 0..2 and to bit 6+k for k in 3..6. The mapping is: abort 5, ring full 6, stop warning 7, transfer error 9, ring operation 10, transfer completion 11, interrupt ready 12. A pulse on an event whose status-enable bit is one sets that status bit, and the bit is readable from the next cycle.
- R3: A pulse on an event whose status-enable bit is zero leaves status unchanged.
- R4: Writing to offset 0x10 clears exactly the status bits written as one and leaves the others.
- R5: When an enabled event and a clear of the same bit fall in the same cycle, the bit ends set.
- R6: A status bit stays set across any number of idle cycles until it is cleared.
- R7: `irq_o` is high exactly when some status bit and the same signal-enable bit are both one. It follows status and signal enable with no further delay.
- R8: Writing ones to offset 0x1C sets the matching status bits on the next cycle, even where status enable is zero. Offset 0x1C always reads zero.
- R9: Only bits 5, 6, 7, 9, 10, 11 and 12 exist (mask 0x1EE0). Other bits read zero and ignore writes. Addresses other than the four offsets read zero, and writes to them change nothing.
- R10: Status enable and signal enable read back the value last written to them, masked to the defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address relative to the ring register base |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_i | input | 7 | One-cycle hardware event pulses |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a clear and an enabled event hitting the same status bit in one clock. The bench reaches it by running one step that asserts the write strobe to offset 0x10 and raises the event pulse for the same bit in the same cycle. It then reads status to confirm the bit survived. A second case drives the force register for a bit whose status enable is off, which shows that forcing bypasses the latch gate.

// File: rtl/ring_irq_bank.sv
module ring_irq_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_EV = 7,
  parameter logic [ADDR_W-1:0] STS_OFF = 8'h10,
  parameter logic [ADDR_W-1:0] SEN_OFF = 8'h14,
  parameter logic [ADDR_W-1:0] GEN_OFF = 8'h18,
  parameter logic [ADDR_W-1:0] FRC_OFF = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EV-1:0] ev_i,
  output logic              irq_o
);

  function automatic int ev_pos(int k);
    return (k < 3) ? 5 + k : 6 + k;
  endfunction

  function automatic logic [DATA_W-1:0] impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_EV; k++) m[ev_pos(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL = impl_mask();

  logic [DATA_W-1:0] sts, sts_en, sig_en;
  logic [DATA_W-1:0] ev_vec, clr, frc;

  always_comb begin
    ev_vec = '0;
    for (int k = 0; k < NUM_EV; k++) ev_vec[ev_pos(k)] = ev_i[k];
  end

  assign clr = (reg_wr && reg_addr == STS_OFF) ? (reg_wdata & IMPL) : '0;
  assign frc = (reg_wr && reg_addr == FRC_OFF) ? (reg_wdata & IMPL) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts    <= '0;
      sts_en <= '0;
      sig_en <= '0;
    end else begin
      sts <= (sts & ~clr) | (ev_vec & sts_en) | frc;
      if (reg_wr && reg_addr == SEN_OFF) sts_en <= reg_wdata & IMPL;
      if (reg_wr && reg_addr == GEN_OFF) sig_en <= reg_wdata & IMPL;
    end
  end

  assign irq_o = |(sts & sig_en);

  always_comb begin
    case (reg_addr)
      STS_OFF: reg_rdata = sts;
      SEN_OFF: reg_rdata = sts_en;
      GEN_OFF: reg_rdata = sig_en;
      default: reg_rdata = '0;
    endcase
  end

  // R2: an enabled event is latched on the next cycle
  a_r2_enabled_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_vec & sts_en) & ~sts) == '0));

  // R3 / R8: a newly set bit must come from an enabled event or a force
  a_r3_no_ungated_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(ev_vec & sts_en) & ~$past(frc)) == '0));

  // R4: written ones clear unless an event hits the same bit
  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STS_OFF) |=> ((sts & $past(reg_wdata) & ~$past(ev_vec)) == '0));

  // R6: set bits are kept unless cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts) & ~$past(clr) & ~sts) == '0));

  // R9: undefined status bits never set
  a_r9_undefined_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts | sts_en | sig_en) & ~IMPL) == '0);

endmodule

// File: tb/test_ring_irq_bank.sv
module test_ring_irq_bank;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  ev_i = '0;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;

  ring_irq_bank i_ring_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_i(ev_i), .irq_o(irq_o)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int bitpos(int k);
    case (k)
      0: return 5;  1: return 6;  2: return 7;  3: return 9;
      4: return 10; 5: return 11; default: return 12;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [7:0] a, logic [31:0] d, logic [6:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; ev_i = ev;
    @(negedge clk);
    reg_wr = 1'b0; ev_i = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h10, v); chk("R1 status", v, 0);
    rd(8'h14, v); chk("R1 sts_en", v, 0);
    rd(8'h18, v); chk("R1 sig_en", v, 0);
    rd(8'h1C, v); chk("R1 force", v, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    step(1, 8'h14, 32'hFFFF_FFFF, 0);
    rd(8'h14, v); chk("R10/R9 sts_en mask", v, 32'h1EE0);
    step(1, 8'h18, 32'h0000_0800, 0);
    rd(8'h18, v); chk("R10 sig_en", v, 32'h0800);
  endtask

  task automatic t_each_event();
    logic [31:0] v;
    for (int k = 0; k < 7; k++) begin
      step(0, 8'h00, 0, 7'(1 << k));
      rd(8'h10, v); chk("R2 latch position", v, 32'(1) << bitpos(k));
      chk("R7 irq follows sig_en", {31'd0, irq_o}, (bitpos(k) == 11) ? 1 : 0);
      step(1, 8'h10, v, 0);
      rd(8'h10, v); chk("R4 write-back clears", v, 0);
    end
  endtask

  task automatic t_gate();
    logic [31:0] v;
    step(1, 8'h14, 32'h0000_0020, 0);
    step(0, 8'h00, 0, 7'h7E);
    rd(8'h10, v); chk("R3 ungated events ignored", v, 0);
    step(0, 8'h00, 0, 7'h7F);
    rd(8'h10, v); chk("R3 only enabled bit latches", v, 32'h0020);
    step(1, 8'h10, 32'h20, 0);
    step(1, 8'h14, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_partial_clear_sticky();
    logic [31:0] v;
    step(0, 8'h00, 0, 7'h7F);
    repeat (20) @(negedge clk);
    rd(8'h10, v); chk("R6 sticky after idle", v, 32'h1EE0);
    step(1, 8'h10, 32'h0A20, 0);
    rd(8'h10, v); chk("R4 partial clear", v, 32'h14C0);
    chk("R7 irq low when bit 11 gone", {31'd0, irq_o}, 0);
    step(1, 8'h18, 32'h0040, 0);
    chk("R7 irq raised by sig_en write", {31'd0, irq_o}, 1);
    step(1, 8'h10, 32'hFFFF_FFFF, 0);
    rd(8'h10, v); chk("R4 clear all", v, 0);
    chk("R7 irq low after clear", {31'd0, irq_o}, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    step(0, 8'h00, 0, 7'h10);
    step(1, 8'h10, 32'h0400, 7'h10);
    rd(8'h10, v); chk("R5 event beats clear", v, 32'h0400);
    step(1, 8'h10, 32'h0400, 0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    step(1, 8'h14, 32'h0, 0);
    step(1, 8'h1C, 32'hFFFF_1800, 0);
    rd(8'h10, v); chk("R8 force sets despite gate", v, 32'h1800);
    rd(8'h1C, v); chk("R8 force reads zero", v, 0);
    step(1, 8'h10, 32'h1800, 0);
  endtask

  task automatic t_undefined();
    logic [31:0] v;
    step(1, 8'h20, 32'hFFFF_FFFF, 0);
    rd(8'h20, v); chk("R9 unmapped reads zero", v, 0);
    rd(8'h10, v); chk("R9 unmapped write no effect", v, 0);
    step(1, 8'h1C, 32'hFFFF_E11F, 0);
    rd(8'h10, v); chk("R9 undefined force bits", v, 0);
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_each_event();
    t_gate();
    t_partial_clear_sticky();
    t_collision();
    t_force();
    t_undefined();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule